// File: doc/BRIEF.md
# Elementary Cellular Automaton Array

This block is a row of N two-state cells that step forward together under radius-1 cellular automaton rules. Every cell reads three bits: its west neighbour, its own state and its east neighbour. That 3-bit index selects one bit of the cell's own 8-bit rule byte, and the selected bit becomes the cell's next state. Each cell has its own rule byte, so a row can mix rules and run as a hybrid automaton.

The two ends of the row are set by a build-time parameter. They are either tied to zero or joined into a ring. An active-low load control copies a per-cell starting pattern into the row. While the load control is released, the row commits a new generation once every PERIOD clock cycles. This stands in for a fixed multi-cycle generation time. Between commits the outputs hold their values. A one-cycle strobe marks each commit.

Top module: `eca_array`

## Requirements
- R1: A cell's next state is bit k of its rule byte, where k = 4*west + 2*self + east. Bit 0 is chosen by neighbourhood 000 and bit 7 by 111. For example, rule 184 gives 111→1, 110→0, 101→1, 100→1, 011→1, 010→0, 001→0, 000→0.
- R2: `state_o[N-1]` is the westmost cell and `state_o[0]` is the eastmost cell. With EDGE = EDGE_ZERO, the west input of cell N-1 and the east input of cell 0 read constant 0.
- R3: With EDGE = EDGE_RING, cell N-1 takes its west input from cell 0, and cell 0 takes its east input from cell N-1.
- R4: On a rising edge where `load_ni` is 0, every cell loads its `init_i` bit. At the same edge the period counter restarts from 0, and no strobe is produced.
- R5: While `load_ni` stays 1, a generation is committed on the PERIOD-th rising edge after the last load or commit, and on no other edge. `state_o` does not change between commits.
- R6: `gen_valid_o` is 1 for exactly the one cycle that follows each commit edge, and 0 at all other times.
- R7: Cell i uses only its own byte `rule_i[8*i+7:8*i]`, so cells may run different rules. `rule_i` is sampled only at commit edges.
- R8: While `rst_ni` is 0, all cell states, the strobe and the period counter are 0. The reset is asynchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | 0 loads `init_i` into the row; 1 lets the row evolve |
| init_i | input | N | Starting pattern, bit i for cell i |
| rule_i | input | 8*N | Rule bytes, byte i for cell i |
| state_o | output | N | Current cell states, bit N-1 is the westmost cell |
| gen_valid_o | output | 1 | One-cycle strobe after each committed generation |

## Verification
The rule-lookup assertions assume that a commit is computed from the states and rule bytes that were present one cycle before the strobe. The bench meets this by changing `rule_i` and `init_i` only just after a rising edge. It sometimes changes a rule in the middle of a period, which is allowed because only the commit edge samples it. The hold and strobe-alignment properties assume that `load_ni` is a plain level. The bench pulses it low for single cycles at arbitrary points in a period, so the counter restart is also exercised when the period has only partly elapsed.

// File: rtl/eca_pkg.sv
`timescale 1ns/1ps
package eca_pkg;

  typedef enum logic {
    EDGE_ZERO = 1'b0,
    EDGE_RING = 1'b1
  } edge_mode_e;

  function automatic logic rule_lookup(input logic [7:0] rule, input logic [2:0] nbhd);
    return rule[nbhd];
  endfunction

endpackage

// File: rtl/eca_cadence.sv
`timescale 1ns/1ps
module eca_cadence #(
  parameter int PERIOD = 6,
  parameter int CW     = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  output logic [CW-1:0] cnt_o,
  output logic          tick_o
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/eca_nbr.sv
`timescale 1ns/1ps
module eca_nbr
  import eca_pkg::*;
#(
  parameter int         N    = 8,
  parameter edge_mode_e EDGE = EDGE_ZERO
) (
  input  logic [N-1:0] state_i,
  output logic [N-1:0] west_o,
  output logic [N-1:0] east_o
);
  // bit N-1 is the west end of the row
  for (genvar i = 0; i < N; i++) begin : g_nbr
    if (i == N-1) begin : g_wedge
      if (EDGE == EDGE_RING) begin : g_wrap
        assign west_o[i] = state_i[0];
      end else begin : g_zero
        assign west_o[i] = 1'b0;
      end
    end else begin : g_wmid
      assign west_o[i] = state_i[i+1];
    end

    if (i == 0) begin : g_eedge
      if (EDGE == EDGE_RING) begin : g_wrap
        assign east_o[i] = state_i[N-1];
      end else begin : g_zero
        assign east_o[i] = 1'b0;
      end
    end else begin : g_emid
      assign east_o[i] = state_i[i-1];
    end
  end

endmodule

// File: rtl/eca_cell.sv
`timescale 1ns/1ps
module eca_cell
  import eca_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_ni,
  input  logic       tick_i,
  input  logic       init_i,
  input  logic [7:0] rule_i,
  input  logic       west_i,
  input  logic       east_i,
  output logic       state_o
);
  logic state_q;
  logic next_s;

  assign next_s = rule_lookup(rule_i, {west_i, state_q, east_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= 1'b0;
    else if (!load_ni) state_q <= init_i;
    else if (tick_i)   state_q <= next_s;
  end

  assign state_o = state_q;

endmodule

// File: rtl/eca_array.sv
`timescale 1ns/1ps
module eca_array
  import eca_pkg::*;
#(
  parameter int         N      = 8,
  parameter int         PERIOD = 6,
  parameter edge_mode_e EDGE   = EDGE_ZERO
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_ni,
  input  logic [N-1:0]   init_i,
  input  logic [8*N-1:0] rule_i,
  output logic [N-1:0]   state_o,
  output logic           gen_valid_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;
  logic          tick;
  logic [N-1:0]  state_q;
  logic [N-1:0]  west;
  logic [N-1:0]  east;
  logic          gen_valid_q;

  eca_cadence #(.PERIOD(PERIOD), .CW(CW)) u_cad (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (load_ni),
    .cnt_o  (cnt_q),
    .tick_o (tick)
  );

  eca_nbr #(.N(N), .EDGE(EDGE)) u_nbr (
    .state_i (state_q),
    .west_o  (west),
    .east_o  (east)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    eca_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_ni (load_ni),
      .tick_i  (tick),
      .init_i  (init_i[i]),
      .rule_i  (rule_i[8*i +: 8]),
      .west_i  (west[i]),
      .east_i  (east[i]),
      .state_o (state_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gen_valid_q <= 1'b0;
    else         gen_valid_q <= tick;
  end

  assign state_o     = state_q;
  assign gen_valid_o = gen_valid_q;

endmodule

// File: rtl/eca_array_chk.sv
`timescale 1ns/1ps
module eca_array_chk
  import eca_pkg::*;
#(
  parameter int         N      = 8,
  parameter int         PERIOD = 6,
  parameter edge_mode_e EDGE   = EDGE_ZERO,
  parameter int         CW     = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           load_ni,
  input logic [N-1:0]   init_i,
  input logic [8*N-1:0] rule_i,
  input logic [N-1:0]   state_o,
  input logic           gen_valid_o,
  input logic [CW-1:0]  cnt_i
);
  logic [N-1:0]   st_q;
  logic [8*N-1:0] rl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      rl_q <= '0;
    end else begin
      st_q <= state_o;
      rl_q <= rule_i;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    logic       w_p;
    logic       e_p;
    logic [2:0] idx;
    if (i == N-1) begin : g_w
      assign w_p = (EDGE == EDGE_RING) ? st_q[0] : 1'b0;
    end else begin : g_wm
      assign w_p = st_q[i+1];
    end
    if (i == 0) begin : g_e
      assign e_p = (EDGE == EDGE_RING) ? st_q[N-1] : 1'b0;
    end else begin : g_em
      assign e_p = st_q[i-1];
    end
    assign idx = {w_p, st_q[i], e_p};

    if (i == 0 || i == N-1) begin : g_edge
      if (EDGE == EDGE_RING) begin : g_ring
        AST_RING_EDGE_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
          gen_valid_o |-> state_o[i] == rl_q[8*i + idx]);  // R3
      end else begin : g_zero
        AST_ZERO_EDGE_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
          gen_valid_o |-> state_o[i] == rl_q[8*i + idx]);  // R2
      end
    end else begin : g_mid
      AST_CELL_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gen_valid_o |-> state_o[i] == rl_q[8*i + idx]);  // R1
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (state_o == '0) && !gen_valid_o && (cnt_i == '0));  // R8

  AST_LOAD_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> (state_o == $past(init_i)) && !gen_valid_o && (cnt_i == '0));  // R4

  AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gen_valid_o && $past(load_ni)) |-> $stable(state_o));  // R5

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(PERIOD - 1));  // R5

  AST_STROBE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_valid_o |-> $past(load_ni) && ($past(cnt_i) == CW'(PERIOD - 1)));  // R6

  if (PERIOD > 1) begin : g_pulse
    AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gen_valid_o |=> !gen_valid_o);  // R6
  end

endmodule

bind eca_array eca_array_chk #(
  .N(N), .PERIOD(PERIOD), .EDGE(EDGE), .CW(CW)
) u_eca_array_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_ni     (load_ni),
  .init_i      (init_i),
  .rule_i      (rule_i),
  .state_o     (state_o),
  .gen_valid_o (gen_valid_o),
  .cnt_i       (cnt_q)
);

// File: tb/eca_array_tb_top.sv
`timescale 1ns/1ps
module eca_array_tb_top;
  import eca_pkg::*;

  localparam int NZ = 5;
  localparam int NR = 10;
  localparam int P  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #2.5 clk = ~clk;

  logic            load_z = 1'b0, load_r = 1'b0;
  logic [NZ-1:0]   init_z = '0;
  logic [NR-1:0]   init_r = '0;
  logic [8*NZ-1:0] rule_z = '0;
  logic [8*NR-1:0] rule_r = '0;
  logic [NZ-1:0]   state_z;
  logic [NR-1:0]   state_r;
  logic            valid_z, valid_r;

  eca_array #(.N(NZ), .PERIOD(P), .EDGE(EDGE_ZERO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_z), .init_i(init_z),
    .rule_i(rule_z), .state_o(state_z), .gen_valid_o(valid_z));

  eca_array #(.N(NR), .PERIOD(P), .EDGE(EDGE_RING)) dut_ring_i (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_r), .init_i(init_r),
    .rule_i(rule_r), .state_o(state_r), .gen_valid_o(valid_r));

  int vecs = 0;
  int fails = 0;
  bit done = 1'b0;
  string tag_z = "R8";
  string tag_r = "R8";

  function automatic logic [15:0] next_gen(logic [15:0] s, logic [127:0] rules, int n, bit ring);
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) begin
      int w, e, k;
      w = (i == n-1) ? (ring ? int'(s[0]) : 0) : int'(s[i+1]);
      e = (i == 0) ? (ring ? int'(s[n-1]) : 0) : int'(s[i-1]);
      k = 4*w + 2*int'(s[i]) + e;
      r[i] = rules[8*i + k];
    end
    return r;
  endfunction

  // behavioural reference
  logic [15:0] mz_s, mr_s;
  int          mz_c, mr_c;
  logic        mz_v, mr_v;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mz_s = '0; mz_c = 0; mz_v = 1'b0;
      mr_s = '0; mr_c = 0; mr_v = 1'b0;
    end else begin
      if (!load_z) begin
        mz_s = 16'(init_z); mz_c = 0; mz_v = 1'b0;
      end else if (mz_c == P-1) begin
        mz_s = next_gen(mz_s, 128'(rule_z), NZ, 1'b0); mz_c = 0; mz_v = 1'b1;
      end else begin
        mz_c++; mz_v = 1'b0;
      end
      if (!load_r) begin
        mr_s = 16'(init_r); mr_c = 0; mr_v = 1'b0;
      end else if (mr_c == P-1) begin
        mr_s = next_gen(mr_s, 128'(rule_r), NR, 1'b1); mr_c = 0; mr_v = 1'b1;
      end else begin
        mr_c++; mr_v = 1'b0;
      end
    end
  end

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // commit spacing observed at the ports (R5)
  logic ld_seen = 1'b0;
  int   gap = 0;
  always @(posedge clk) ld_seen <= load_z;

  always @(negedge clk) begin
    if (!done) begin
      chk(tag_z, 16'(state_z), mz_s);
      chk("R6", 16'(valid_z), 16'(mz_v));
      chk(tag_r, 16'(state_r), mr_s);
      chk("R6", 16'(valid_r), 16'(mr_v));
      if (!ld_seen || !rst_n) gap = 0;
      else begin
        gap++;
        if (valid_z) begin
          chk("R5", 16'(gap), 16'(P));
          gap = 0;
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wait_gen();
    @(negedge clk);
    while (!valid_z) @(negedge clk);
  endtask

  function automatic logic [8*NZ-1:0] fill_z(logic [7:0] r);
    return {NZ{r}};
  endfunction

  function automatic logic [8*NR-1:0] fill_r(logic [7:0] r);
    return {NR{r}};
  endfunction

  initial begin
    #2 rst_n = 1'b0;
    step(3);
    @(negedge clk);
    chk("R8", 16'(state_z), 16'h0);
    chk("R8", 16'(valid_r), 16'h0);
    step(1);
    rst_n = 1'b1;

    // R4: load starting patterns
    tag_z = "R4"; tag_r = "R4";
    rule_z = fill_z(8'd30);
    rule_r = fill_r(8'd90);
    init_z = 5'b00010;
    init_r = 10'b0000000100;
    step(2);
    @(negedge clk);
    chk("R4", 16'(state_z), 16'b00010);
    chk("R4", 16'(state_r), 16'b0000000100);
    step(1);
    load_z = 1'b1; load_r = 1'b1;
    tag_z = "R2"; tag_r = "R3";

    wait_gen();
    chk("R2", 16'(state_z), 16'b00111);
    chk("R3", 16'(state_r), 16'b0000001010);
    wait_gen();
    chk("R2", 16'(state_z), 16'b01100);
    chk("R3", 16'(state_r), 16'b0000010001);
    step(1);
    step(P * 18);

    // R1: rule 184 traffic flow
    tag_z = "R1";
    rule_z = fill_z(8'd184);
    init_z = 5'b11010;
    load_z = 1'b0;
    step(1);
    load_z = 1'b1;
    step(P * 12);

    // R7: hybrid rows, rule changed mid-period
    tag_z = "R7"; tag_r = "R7";
    rule_z = {8'd30, 8'd90, 8'd110, 8'd184, 8'd150};
    for (int i = 0; i < NR; i++) rule_r[8*i +: 8] = 8'((i * 37 + 11) & 255);
    init_z = 5'b10011;
    init_r = 10'b1001101001;
    load_z = 1'b0; load_r = 1'b0;
    step(1);
    load_z = 1'b1; load_r = 1'b1;
    step(P * 6 + 2);
    rule_z[15:8] = 8'd105;
    step(P * 8);

    // R4: single-cycle loads part-way through a period
    tag_z = "R4"; tag_r = "R4";
    step(3);
    init_z = 5'b01001;
    load_z = 1'b0;
    step(1);
    load_z = 1'b1;
    step(4);
    init_r = 10'b0110000001;
    load_r = 1'b0;
    step(1);
    load_r = 1'b1;
    step(P * 10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

endmodule